// File: doc/BRIEF.md
# FIFO Level and Error Interrupt Unit

This unit watches the fill counts of a write (transmit) FIFO and a read (receive) FIFO. It compares each count against a selectable fractional threshold and raises a service request for each FIFO. The write FIFO asks for data while it is at or below its threshold. The read FIFO asks to be drained while it is at or above its threshold.

The unit also records three error events in sticky bits: a write attempt while the write FIFO is full, a stalled read, and a hold-off timeout. Each error source has its own enable. A hold-off timer counts clock cycles while a transaction is held off and the external ready input is low. When the count passes a programmable maximum, the unit aborts the transaction with a one-cycle pulse. A maximum of zero disables the timer.

Software sees three views: a raw status word, a masked status word and the sticky error word. The error word is cleared by writing ones. A single interrupt line is the OR of the masked status bits.

Top module: `fifo_irq_unit`

## Requirements
- R1: The write-FIFO request (raw_status bit 0) is registered. One clock after the inputs are applied it is 1 exactly when tx_level <= tx_trig_sel * TX_DEPTH / 4. The tx_trig_sel codes are 0 = empty, 1 = quarter, 2 = half, 3 = three quarters.
- R2: The read-FIFO request (raw_status bit 1) is registered. One clock after the inputs are applied it is 1 exactly when rx_level >= the threshold picked by rx_trig_sel. The codes are 0 = 1/8, 1 = 1/4, 2 = 1/2, 3 = 3/4 and 4 = 7/8 of RX_DEPTH. Codes 5, 6 and 7 all mean the full depth.
- R3: At a clock edge where wr_attempt is high, tx_level equals TX_DEPTH and err_enable bit 0 is set, err_status bit 0 becomes 1. A write attempt below full sets nothing.
- R4: At a clock edge where rd_stall is high and err_enable bit 1 is set, err_status bit 1 becomes 1.
- R5: The hold-off timer counts edges at which hold_off is high, ext_ready is low and max_wait is nonzero. Counting starts at zero. At the (max_wait+1)-th consecutive such edge, abort_pulse is high for exactly one cycle and the count restarts. At that same edge err_status bit 2 is set if err_enable bit 2 is set.
- R6: When max_wait is 0, no abort ever occurs. The count also returns to zero at any edge where ext_ready is high or hold_off is low.
- R7: An event whose err_enable bit is 0 leaves its err_status bit unchanged. A timeout still aborts the transaction when its enable bit is 0.
- R8: A cycle with err_clr_wr high clears every err_status bit whose err_clr_bits position is 1. Positions holding 0 keep their value.
- R9: When a new event and a clear of the same bit land on the same edge, the bit stays 1.
- R10: raw_status bit 2 is 1 whenever any err_status bit is 1, and 0 when all are 0.
- R11: masked_status equals raw_status AND int_mask, bit for bit. irq is the OR of masked_status. A mask change shows on both outputs in the same cycle.
- R12: While rst_n is low, raw_status, masked_status, err_status, irq and abort_pulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_level | input | clog2(TX_DEPTH+1) | Write FIFO occupancy |
| rx_level | input | clog2(RX_DEPTH+1) | Read FIFO occupancy |
| tx_trig_sel | input | 2 | Write FIFO threshold code |
| rx_trig_sel | input | 3 | Read FIFO threshold code |
| wr_attempt | input | 1 | Write strobe into the write FIFO |
| rd_stall | input | 1 | Read stall event strobe |
| hold_off | input | 1 | Transaction is being held off |
| ext_ready | input | 1 | External device ready |
| max_wait | input | WAIT_W | Hold-off limit; 0 waits forever |
| err_enable | input | 3 | Per-source error enables (0 full write, 1 stall, 2 timeout) |
| int_mask | input | 3 | Interrupt mask over raw_status |
| err_clr_wr | input | 1 | Clear strobe for err_status |
| err_clr_bits | input | 3 | Ones select the error bits to clear |
| raw_status | output | 3 | {error summary, read request, write request} |
| masked_status | output | 3 | raw_status AND int_mask |
| err_status | output | 3 | Sticky error bits |
| irq | output | 1 | Interrupt line |
| abort_pulse | output | 1 | One-cycle abort on timeout |

## Verification
The threshold comparators are driven with a table of level/threshold pairs. Each pair sits either exactly on a trigger point or one entry past it, so the tests separate an at-or-below comparison from a strictly-below one, and an at-or-above comparison from a strictly-above one. The table also feeds out-of-range receive codes, to show they fold onto the full threshold. Error tests apply each strobe with its enable on and then off. They also clear with ones in unrelated positions and collide a new event with its own clear, which separates sticky, gated and set-priority behaviour. The hold-off timer is run in four ways: held continuously, with a zero limit, with ready pulses that arrive before the limit, and with the timeout enable off. These separate an off-by-one limit, a missing ready restart, a missing forever mode and an abort gated by the enable.

// File: rtl/fiu_pkg.sv
package fiu_pkg;

   localparam int STAT_W   = 3;
   localparam int ST_TXREQ = 0;
   localparam int ST_RXREQ = 1;
   localparam int ST_ERR   = 2;

   localparam int ERR_W    = 3;
   localparam int E_WRFULL = 0;
   localparam int E_STALL  = 1;
   localparam int E_TMO    = 2;

   typedef enum logic [1:0] {
      TXT_EMPTY   = 2'd0,
      TXT_QUARTER = 2'd1,
      TXT_HALF    = 2'd2,
      TXT_3QTR    = 2'd3
   } tx_trig_e;

   typedef enum logic [2:0] {
      RXT_EIGHTH  = 3'd0,
      RXT_QUARTER = 3'd1,
      RXT_HALF    = 3'd2,
      RXT_3QTR    = 3'd3,
      RXT_7EIGHTH = 3'd4,
      RXT_FULL    = 3'd5
   } rx_trig_e;

   // Write-side threshold: the code counts quarters of the depth.
   function automatic int tx_trig_level(input logic [1:0] sel, input int depth);
      return (int'(sel) * depth) / 4;
   endfunction

   // Read-side threshold; codes above the full code fold onto full.
   function automatic int rx_trig_level(input logic [2:0] sel, input int depth);
      case (sel)
         RXT_EIGHTH:  return depth / 8;
         RXT_QUARTER: return depth / 4;
         RXT_HALF:    return depth / 2;
         RXT_3QTR:    return (3 * depth) / 4;
         RXT_7EIGHTH: return (7 * depth) / 8;
         default:     return depth;
      endcase
   endfunction

endpackage

// File: rtl/fiu_level_cmp.sv
module fiu_level_cmp #(
   parameter int DEPTH = 16,
   parameter bit ABOVE = 1'b0,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] trig,
   output logic             req
);

   logic hit;

   generate
      if (ABOVE) begin : g_above
         assign hit = (level >= trig);
      end else begin : g_below
         assign hit = (level <= trig);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= hit;
   end

endmodule

// File: rtl/fiu_wait_timer.sv
module fiu_wait_timer #(
   parameter int WAIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_off,
   input  logic              ext_ready,
   input  logic [WAIT_W-1:0] max_wait,
   output logic              expire,
   output logic              abort_pulse
);

   logic [WAIT_W-1:0] cnt;
   logic              counting;

   // A zero limit disables counting, so the wait never ends.
   assign counting = hold_off && !ext_ready && (max_wait != '0);
   assign expire   = counting && (cnt == max_wait);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt         <= '0;
         abort_pulse <= 1'b0;
      end else begin
         abort_pulse <= expire;
         if (!counting || expire) cnt <= '0;
         else                     cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/fiu_err_latch.sv
module fiu_err_latch #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] en,
   input  logic         clr_wr,
   input  logic [N-1:0] clr_bits,
   output logic [N-1:0] sticky
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    sticky[i] <= 1'b0;
            else if (evt[i] && en[i])      sticky[i] <= 1'b1;
            else if (clr_wr && clr_bits[i]) sticky[i] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit #(
   parameter int TX_DEPTH = 16,
   parameter int RX_DEPTH = 16,
   parameter int WAIT_W   = 8,
   localparam int TXC_W   = $clog2(TX_DEPTH + 1),
   localparam int RXC_W   = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TXC_W-1:0]  tx_level,
   input  logic [RXC_W-1:0]  rx_level,
   input  logic [1:0]        tx_trig_sel,
   input  logic [2:0]        rx_trig_sel,
   input  logic              wr_attempt,
   input  logic              rd_stall,
   input  logic              hold_off,
   input  logic              ext_ready,
   input  logic [WAIT_W-1:0] max_wait,
   input  logic [2:0]        err_enable,
   input  logic [2:0]        int_mask,
   input  logic              err_clr_wr,
   input  logic [2:0]        err_clr_bits,
   output logic [2:0]        raw_status,
   output logic [2:0]        masked_status,
   output logic [2:0]        err_status,
   output logic              irq,
   output logic              abort_pulse
);
   import fiu_pkg::*;

   generate
      if (TX_DEPTH < 4 || (TX_DEPTH % 4) != 0) begin : g_bad_tx
         $error("TX_DEPTH must be a positive multiple of 4");
      end
      if (RX_DEPTH < 8 || (RX_DEPTH % 8) != 0) begin : g_bad_rx
         $error("RX_DEPTH must be a positive multiple of 8");
      end
      if (WAIT_W < 1) begin : g_bad_wait
         $error("WAIT_W must be at least 1");
      end
   endgenerate

   logic [TXC_W-1:0] tx_trig;
   logic [RXC_W-1:0] rx_trig;
   logic             tx_req;
   logic             rx_req;
   logic             tmo_expire;
   logic [ERR_W-1:0] err_evt;

   assign tx_trig = TXC_W'(tx_trig_level(tx_trig_sel, TX_DEPTH));
   assign rx_trig = RXC_W'(rx_trig_level(rx_trig_sel, RX_DEPTH));

   fiu_level_cmp #(.DEPTH(TX_DEPTH), .ABOVE(1'b0), .CNT_W(TXC_W)) u_tx_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .level (tx_level),
      .trig  (tx_trig),
      .req   (tx_req)
   );

   fiu_level_cmp #(.DEPTH(RX_DEPTH), .ABOVE(1'b1), .CNT_W(RXC_W)) u_rx_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .level (rx_level),
      .trig  (rx_trig),
      .req   (rx_req)
   );

   fiu_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_off    (hold_off),
      .ext_ready   (ext_ready),
      .max_wait    (max_wait),
      .expire      (tmo_expire),
      .abort_pulse (abort_pulse)
   );

   always_comb begin
      err_evt           = '0;
      err_evt[E_WRFULL] = wr_attempt && (tx_level >= TXC_W'(TX_DEPTH));
      err_evt[E_STALL]  = rd_stall;
      err_evt[E_TMO]    = tmo_expire;
   end

   fiu_err_latch #(.N(ERR_W)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (err_evt),
      .en       (err_enable),
      .clr_wr   (err_clr_wr),
      .clr_bits (err_clr_bits),
      .sticky   (err_status)
   );

   always_comb begin
      raw_status           = '0;
      raw_status[ST_TXREQ] = tx_req;
      raw_status[ST_RXREQ] = rx_req;
      raw_status[ST_ERR]   = |err_status;
   end

   assign masked_status = raw_status & int_mask;
   assign irq           = |masked_status;

endmodule

// File: rtl/fifo_irq_unit_chk.sv
module fifo_irq_unit_chk #(
   parameter int TX_DEPTH = 16,
   parameter int WAIT_W   = 8,
   localparam int TXC_W   = $clog2(TX_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TXC_W-1:0]  tx_level,
   input logic              wr_attempt,
   input logic              rd_stall,
   input logic              ext_ready,
   input logic [WAIT_W-1:0] max_wait,
   input logic [2:0]        err_enable,
   input logic [2:0]        int_mask,
   input logic              err_clr_wr,
   input logic [2:0]        err_clr_bits,
   input logic [2:0]        err_status,
   input logic              irq,
   input logic              abort_pulse
);

   p_full_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_attempt && tx_level == TXC_W'(TX_DEPTH) && err_enable[0]) |=> err_status[0]);

   p_stall_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stall && err_enable[1]) |=> err_status[1]);

   p_abort_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |=> !abort_pulse);

   p_wait_forever_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (max_wait == '0) |=> !abort_pulse);

   p_ready_no_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ready |=> !abort_pulse);

   p_gated_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_enable[1] && !err_status[1]) |=> !err_status[1]);

   p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr_wr && err_clr_bits[1] && !rd_stall) |=> !err_status[1]);

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stall && err_enable[1] && err_clr_wr && err_clr_bits[1]) |=> err_status[1]);

   p_mask_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mask == 3'b000) |-> !irq);

endmodule

bind fifo_irq_unit fifo_irq_unit_chk #(.TX_DEPTH(TX_DEPTH), .WAIT_W(WAIT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_level     (tx_level),
   .wr_attempt   (wr_attempt),
   .rd_stall     (rd_stall),
   .ext_ready    (ext_ready),
   .max_wait     (max_wait),
   .err_enable   (err_enable),
   .int_mask     (int_mask),
   .err_clr_wr   (err_clr_wr),
   .err_clr_bits (err_clr_bits),
   .err_status   (err_status),
   .irq          (irq),
   .abort_pulse  (abort_pulse)
);

// File: tb/fifo_irq_unit_bench.sv
module fifo_irq_unit_bench;

   localparam int TXD = 16;
   localparam int RXD = 16;
   localparam int WW  = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] tx_level = '0;
   logic [4:0] rx_level = '0;
   logic [1:0] tx_trig_sel = '0;
   logic [2:0] rx_trig_sel = '0;
   logic       wr_attempt = 1'b0;
   logic       rd_stall = 1'b0;
   logic       hold_off = 1'b0;
   logic       ext_ready = 1'b0;
   logic [7:0] max_wait = '0;
   logic [2:0] err_enable = '0;
   logic [2:0] int_mask = '0;
   logic       err_clr_wr = 1'b0;
   logic [2:0] err_clr_bits = '0;
   logic [2:0] raw_status;
   logic [2:0] masked_status;
   logic [2:0] err_status;
   logic       irq;
   logic       abort_pulse;

   int n_chk  = 0;
   int n_fail = 0;
   int aborts;

   always #2 clk = ~clk;

   fifo_irq_unit #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .WAIT_W(WW)) u_fifo_irq_unit (
      .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
      .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
      .wr_attempt(wr_attempt), .rd_stall(rd_stall), .hold_off(hold_off),
      .ext_ready(ext_ready), .max_wait(max_wait), .err_enable(err_enable),
      .int_mask(int_mask), .err_clr_wr(err_clr_wr), .err_clr_bits(err_clr_bits),
      .raw_status(raw_status), .masked_status(masked_status),
      .err_status(err_status), .irq(irq), .abort_pulse(abort_pulse)
   );

   // {tx_sel[2], tx_level[5], rx_sel[3], rx_level[5], exp_tx, exp_rx}
   localparam logic [16:0] VEC [12] = '{
      {2'd0, 5'd0,  3'd0, 5'd2,  1'b1, 1'b1},
      {2'd0, 5'd1,  3'd0, 5'd1,  1'b0, 1'b0},
      {2'd1, 5'd4,  3'd1, 5'd3,  1'b1, 1'b0},
      {2'd1, 5'd5,  3'd1, 5'd4,  1'b0, 1'b1},
      {2'd2, 5'd8,  3'd2, 5'd7,  1'b1, 1'b0},
      {2'd2, 5'd9,  3'd2, 5'd8,  1'b0, 1'b1},
      {2'd3, 5'd12, 3'd3, 5'd11, 1'b1, 1'b0},
      {2'd3, 5'd13, 3'd4, 5'd14, 1'b0, 1'b1},
      {2'd3, 5'd16, 3'd5, 5'd15, 1'b0, 1'b0},
      {2'd0, 5'd16, 3'd5, 5'd16, 1'b0, 1'b1},
      {2'd2, 5'd0,  3'd7, 5'd16, 1'b1, 1'b1},
      {2'd1, 5'd3,  3'd6, 5'd15, 1'b1, 1'b0}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic edge_sample();
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      chk("R12 raw", {5'b0, raw_status}, 8'h0);
      chk("R12 err", {5'b0, err_status}, 8'h0);
      chk("R12 irq/abort", {6'b0, irq, abort_pulse}, 8'h0);
      chk("R12 masked", {5'b0, masked_status}, 8'h0);
      rst_n = 1'b1;

      // R1 / R2: threshold table
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         tx_trig_sel = VEC[i][16:15];
         tx_level    = VEC[i][14:10];
         rx_trig_sel = VEC[i][9:7];
         rx_level    = VEC[i][6:2];
         edge_sample();
         chk($sformatf("R1 vec%0d", i), {7'b0, raw_status[0]}, {7'b0, VEC[i][1]});
         chk($sformatf("R2 vec%0d", i), {7'b0, raw_status[1]}, {7'b0, VEC[i][0]});
      end

      // R11: mask over request bits
      @(negedge clk);
      tx_trig_sel = 2'd0; tx_level = 5'd0; rx_trig_sel = 3'd5; rx_level = 5'd0;
      int_mask = 3'b001;
      edge_sample();
      chk("R11 masked tx", {5'b0, masked_status}, 8'h01);
      chk("R11 irq on", {7'b0, irq}, 8'h01);
      @(negedge clk);
      int_mask = 3'b010;
      #1;
      chk("R11 irq off", {7'b0, irq}, 8'h00);

      // Park both requests low for the error tests
      @(negedge clk);
      int_mask = 3'b000;
      tx_trig_sel = 2'd3; tx_level = 5'd16; rx_trig_sel = 3'd5; rx_level = 5'd0;
      err_enable = 3'b111;
      wr_attempt = 1'b1;
      edge_sample();
      chk("R3 full write", {5'b0, err_status}, 8'h01);
      chk("R10 summary set", {7'b0, raw_status[2]}, 8'h01);

      // R8: ones in other positions do not touch bit 0
      @(negedge clk);
      wr_attempt = 1'b0;
      err_clr_wr = 1'b1; err_clr_bits = 3'b110;
      edge_sample();
      chk("R8 zero keeps", {5'b0, err_status}, 8'h01);
      @(negedge clk);
      err_clr_bits = 3'b001;
      edge_sample();
      chk("R8 clear", {5'b0, err_status}, 8'h00);
      chk("R10 summary clear", {7'b0, raw_status[2]}, 8'h00);

      // R3: write below full is harmless
      @(negedge clk);
      err_clr_wr = 1'b0; err_clr_bits = 3'b000;
      tx_level = 5'd15; wr_attempt = 1'b1;
      edge_sample();
      chk("R3 not full", {5'b0, err_status}, 8'h00);

      // R7: disabled stall
      @(negedge clk);
      wr_attempt = 1'b0;
      err_enable = 3'b101; rd_stall = 1'b1;
      edge_sample();
      chk("R7 stall gated", {5'b0, err_status}, 8'h00);

      // R4: enabled stall
      @(negedge clk);
      err_enable = 3'b111;
      edge_sample();
      chk("R4 stall", {5'b0, err_status}, 8'h02);

      // R9: event and clear on the same edge
      @(negedge clk);
      err_clr_wr = 1'b1; err_clr_bits = 3'b010;
      edge_sample();
      chk("R9 set wins", {5'b0, err_status}, 8'h02);
      @(negedge clk);
      rd_stall = 1'b0;
      edge_sample();
      chk("R8 clear stall", {5'b0, err_status}, 8'h00);

      // R11: error summary through the mask
      @(negedge clk);
      err_clr_wr = 1'b0; err_clr_bits = 3'b000;
      rd_stall = 1'b1;
      edge_sample();
      @(negedge clk);
      rd_stall = 1'b0;
      int_mask = 3'b100;
      #1;
      chk("R11 err masked", {5'b0, masked_status}, 8'h04);
      chk("R11 err irq", {7'b0, irq}, 8'h01);
      int_mask = 3'b011;
      #1;
      chk("R11 err hidden", {6'b0, irq, masked_status[2]}, 8'h00);
      @(negedge clk);
      int_mask = 3'b000;
      err_clr_wr = 1'b1; err_clr_bits = 3'b111;
      @(negedge clk);
      err_clr_wr = 1'b0; err_clr_bits = 3'b000;

      // R5: timeout after max_wait+1 held edges
      max_wait = 8'd3; hold_off = 1'b1; ext_ready = 1'b0;
      for (int k = 1; k <= 5; k++) begin
         edge_sample();
         chk($sformatf("R5 abort edge%0d", k), {7'b0, abort_pulse}, (k == 4) ? 8'h01 : 8'h00);
         if (k == 4) chk("R5 timeout err", {5'b0, err_status}, 8'h04);
      end
      @(negedge clk);
      hold_off = 1'b0;
      err_clr_wr = 1'b1; err_clr_bits = 3'b111;
      @(negedge clk);
      err_clr_wr = 1'b0; err_clr_bits = 3'b000;

      // R6: zero limit waits forever
      max_wait = 8'd0; hold_off = 1'b1;
      aborts = 0;
      for (int k = 0; k < 300; k++) begin
         edge_sample();
         if (abort_pulse) aborts++;
      end
      chk("R6 forever", aborts[7:0], 8'h00);

      // R6: ready restarts the count before the limit
      max_wait = 8'd3;
      aborts = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         ext_ready = (k % 3 == 2);
         edge_sample();
         if (abort_pulse) aborts++;
      end
      chk("R6 ready restart", aborts[7:0], 8'h00);
      @(negedge clk);
      hold_off = 1'b0; ext_ready = 1'b0;

      // R7: timeout disabled still aborts, no error bit
      @(negedge clk);
      err_enable = 3'b011; max_wait = 8'd2; hold_off = 1'b1;
      for (int k = 1; k <= 3; k++) begin
         edge_sample();
         chk($sformatf("R5 short abort edge%0d", k), {7'b0, abort_pulse}, (k == 3) ? 8'h01 : 8'h00);
      end
      chk("R7 timeout gated", {5'b0, err_status}, 8'h00);
      @(negedge clk);
      hold_off = 1'b0;

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule